// File: doc/BRIEF.md
# Flash Mode Entry Sequence Detector

This block watches the mode-register writes that a system controller accepts, and arms flash programming only after a deliberate handshake. Software has to write the Normal code and the Flash code in turn, Normal first, until four writes are done. Each write must land in the open write window of the watchdog, and each must fall in its own watchdog period, with the periods following one another. Any step out of line drops the detector back to idle.

When the fourth write is accepted, the block holds a system reset request for a fixed number of clock cycles and then waits in a start-up state. A millisecond tick drives a deadline counter. If software writes the initializing-flash code before the deadline runs out, the block gives a one-cycle entry pulse. If the deadline runs out first, it gives a one-cycle failure pulse. In both cases it returns to idle.

Mode codes are parameters. The defaults are Normal = 3'b001, Flash = 3'b011 and Init = 3'b101. A write is accepted when `wr_stb` is high while `win_open` is high. `period_end` is a one-cycle strobe that marks the last cycle of a watchdog period.

Top module: `flash_entry_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `rst_req`, `flash_entered` and `seq_fail` are all low.
- R2: Four accepted writes with the codes Normal (3'b001), Flash (3'b011), Normal, Flash, one in each of four consecutive watchdog periods, complete the sequence.
- R3: A write while `win_open` is low, made after the first step, aborts the sequence to idle.
- R4: A write with a code other than the next one expected, made after the first step, aborts to idle. The aborting write does not count as a new first step.
- R5: A second write within the same watchdog period, made after the first step, aborts to idle.
- R6: A `period_end` strobe in a period that had no write, once the sequence has started, aborts to idle.
- R7: `rst_req` rises in the cycle after the fourth write is accepted and stays high for exactly RST_CYCLES (16) clock cycles.
- R8: After `rst_req` falls, a write of the Init code (3'b101) made before the deadline gives exactly one cycle of `flash_entered`. The detector then returns to idle.
- R9: If DEADLINE_MS (256) `ms_tick` pulses pass after `rst_req` falls with no Init write, `seq_fail` pulses for one cycle. No pulse appears after 255 ticks.
- R10: A write in the same cycle as `period_end` counts for the period that is ending. The next period is then free for the next step.
- R11: An Init write in the same cycle as the last deadline tick wins: `flash_entered` pulses and `seq_fail` does not.
- R12: Writes made while `rst_req` is high, and non-Init writes made during the deadline wait, have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Mode-register write strobe |
| wr_code | input | CODE_W | Mode code being written |
| win_open | input | 1 | Watchdog write window is open |
| period_end | input | 1 | Last cycle of a watchdog period |
| ms_tick | input | 1 | One-cycle millisecond tick |
| rst_req | output | 1 | Forced system reset request |
| flash_entered | output | 1 | One-cycle pulse: flash mode entered |
| seq_fail | output | 1 | One-cycle pulse: init deadline missed |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a sequence write and the period boundary, which decides whether the step is credited to the period that is closing. The second pair is the Init write and the final deadline tick, which decides which outcome wins. The bench drives each step write together with `period_end`, and expects the forced reset after the fourth. It then sends 255 ticks and puts the Init write on the 256th tick. The scoreboard must then see an entry pulse and no failure pulse.

// File: rtl/flash_entry_seq.sv
module flash_entry_seq #(
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] CODE_NORMAL = 3'b001,
  parameter logic [CODE_W-1:0] CODE_FLASH  = 3'b011,
  parameter logic [CODE_W-1:0] CODE_INIT   = 3'b101,
  parameter int RST_CYCLES  = 16,
  parameter int DEADLINE_MS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              win_open,
  input  logic              period_end,
  input  logic              ms_tick,
  output logic              rst_req,
  output logic              flash_entered,
  output logic              seq_fail
);
  localparam int CNT_MAX = (RST_CYCLES > DEADLINE_MS) ? RST_CYCLES : DEADLINE_MS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_S1, ST_S2, ST_S3, ST_RST, ST_WAIT} st_t;

  st_t              st;
  logic             wrote;
  logic [CNT_W-1:0] cnt;
  logic             ent_q, fail_q;
  logic [CODE_W-1:0] want;
  logic             stepping, good_step, init_wr;

  assign stepping  = (st == ST_S1) || (st == ST_S2) || (st == ST_S3);
  assign want      = (st == ST_S2) ? CODE_NORMAL : CODE_FLASH;
  assign good_step = wr_stb && win_open && !wrote && (wr_code == want);
  assign init_wr   = wr_stb && (wr_code == CODE_INIT);

  assign rst_req       = (st == ST_RST);
  assign flash_entered = ent_q;
  assign seq_fail      = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      wrote  <= 1'b0;
      cnt    <= '0;
      ent_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      ent_q  <= 1'b0;
      fail_q <= 1'b0;
      if (st == ST_IDLE) begin
        wrote <= 1'b0;
        if (wr_stb && win_open && wr_code == CODE_NORMAL) begin
          st    <= ST_S1;
          wrote <= !period_end;
        end
      end else if (stepping) begin
        if (wr_stb) begin
          if (good_step) begin
            wrote <= !period_end;
            if (st == ST_S3) begin
              st  <= ST_RST;
              cnt <= '0;
            end else begin
              st <= (st == ST_S1) ? ST_S2 : ST_S3;
            end
          end else begin
            st <= ST_IDLE;
          end
        end else if (period_end) begin
          if (!wrote) st <= ST_IDLE;
          else        wrote <= 1'b0;
        end
      end else if (st == ST_RST) begin
        if (cnt == CNT_W'(RST_CYCLES - 1)) begin
          st  <= ST_WAIT;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (st == ST_WAIT) begin
        if (init_wr) begin
          ent_q <= 1'b1;
          st    <= ST_IDLE;
        end else if (ms_tick) begin
          if (cnt == CNT_W'(DEADLINE_MS - 1)) begin
            fail_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else begin
        st <= ST_IDLE;
      end
    end
  end

  a_r7_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && cnt != CNT_W'(RST_CYCLES - 1)) |=> rst_req);
  a_r2_fall_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (st == ST_WAIT));
  a_r8_entry_single: assert property (@(posedge clk) disable iff (!rst_n)
    flash_entered |=> !flash_entered);
  a_r9_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fail |=> !seq_fail);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_entered && seq_fail));
  a_r12_no_reset_at_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_entered || seq_fail) |-> !rst_req);
endmodule

// File: tb/flash_entry_seq_bench.sv
module flash_entry_seq_bench;
  localparam logic [2:0] NRM = 3'b001, FLS = 3'b011, INI = 3'b101, BAD = 3'b110;
  localparam int EV_RST = 1, EV_ENT = 2, EV_FAIL = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_stb = 0, win_open = 0, period_end = 0, ms_tick = 0;
  logic [2:0] wr_code = '0;
  logic rst_req, flash_entered, seq_fail;

  int tests = 0, fails = 0;
  int q[$];
  string cur_req = "R1";
  int run_len = 0;

  always #2 clk = ~clk;

  flash_entry_seq u_flash_entry_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_code(wr_code),
    .win_open(win_open), .period_end(period_end), .ms_tick(ms_tick),
    .rst_req(rst_req), .flash_entered(flash_entered), .seq_fail(seq_fail));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic got(input int item);
    int e;
    if (q.size() == 0) begin
      tests++; fails++;
      $display("FAIL %s unexpected event actual=%0d expected=none", cur_req, item);
    end else begin
      e = q.pop_front();
      check(cur_req, item, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) run_len++;
      else if (run_len != 0) begin got(EV_RST * 100 + run_len); run_len = 0; end
      if (flash_entered) got(EV_ENT * 100);
      if (seq_fail) got(EV_FAIL * 100);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic w, input logic [2:0] c, input logic win,
                       input logic pe, input logic tk);
    @(negedge clk);
    wr_stb = w; wr_code = c; win_open = win; period_end = pe; ms_tick = tk;
    @(negedge clk);
    wr_stb = 0; win_open = 0; period_end = 0; ms_tick = 0;
  endtask

  task automatic step(input logic [2:0] c, input logic win);
    drive(1, c, win, 0, 0);
    cyc(2);
    drive(0, '0, 0, 1, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, 0, 0, 1);
  endtask

  task automatic wait_rst_done;
    while (!rst_req) @(negedge clk);
    while (rst_req) @(negedge clk);
  endtask

  task automatic drained(input string req);
    cyc(4);
    check(req, q.size(), 0);
  endtask

  initial begin
    #(200000 * 4);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(2);
    check("R1", rst_req + flash_entered + seq_fail, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", rst_req + flash_entered + seq_fail, 0);

    cur_req = "R2";
    q.push_back(EV_RST * 100 + 16); q.push_back(EV_ENT * 100);
    step(NRM, 1); step(FLS, 1); step(NRM, 1);
    @(negedge clk); wr_stb = 1; wr_code = FLS; win_open = 1;
    @(negedge clk); wr_stb = 0; win_open = 0;
    check("R7", rst_req, 1);
    cur_req = "R12";
    drive(1, INI, 1, 0, 0);
    while (rst_req) @(negedge clk);
    cur_req = "R8";
    ticks(10);
    drive(1, BAD, 1, 0, 0);
    ticks(5);
    drive(1, INI, 1, 0, 0);
    drained("R8");

    cur_req = "R9";
    q.push_back(EV_RST * 100 + 16); q.push_back(EV_FAIL * 100);
    step(NRM, 1); step(FLS, 1); step(NRM, 1); step(FLS, 1);
    wait_rst_done;
    ticks(255);
    check("R9", q.size(), 1);
    ticks(1);
    drained("R9");

    cur_req = "R3";
    step(NRM, 1); step(FLS, 1); step(NRM, 0); step(FLS, 1);
    drained("R3");

    cur_req = "R4";
    step(NRM, 1); step(NRM, 1); step(FLS, 1); step(NRM, 1); step(FLS, 1);
    drained("R4");

    cur_req = "R5";
    drive(1, NRM, 1, 0, 0); drive(1, FLS, 1, 0, 0); drive(0, '0, 0, 1, 0);
    step(FLS, 1); step(NRM, 1); step(FLS, 1);
    drained("R5");

    cur_req = "R6";
    step(NRM, 1); drive(0, '0, 0, 1, 0);
    step(FLS, 1); step(NRM, 1); step(FLS, 1);
    drained("R6");

    cur_req = "R10";
    q.push_back(EV_RST * 100 + 16); q.push_back(EV_ENT * 100);
    drive(1, NRM, 1, 1, 0); drive(1, FLS, 1, 1, 0);
    drive(1, NRM, 1, 1, 0); drive(1, FLS, 1, 1, 0);
    wait_rst_done;
    cur_req = "R11";
    ticks(255);
    drive(1, INI, 1, 0, 1);
    drained("R11");
    check("R11", seq_fail, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule